// File: doc/BRIEF.md
# SECDED-Protected Single-Port RAM with Check-Code Injection

This block wraps a single-port synchronous RAM and guards every stored data word with an extended Hamming code. On a write it computes the position parity bits and one overall parity bit and stores them next to the data. On a read it recomputes the parity bits from the stored data, forms a syndrome, repairs any single flipped bit and reports double flips as uncorrectable. It does not repair the stored word.

For testing error handling, a write can corrupt the stored check code on purpose. The corruption style is fixed when the block is built, through the parameter `INJ_MODE`. In direct style (`INJ_MODE=0`) the caller supplies the whole check code, which replaces the generated one. In mask style (`INJ_MODE=1`) the caller supplies a mask, which is XORed onto the generated code. With the default 32-bit data word the code has 7 check bits, so each stored word is 39 bits wide.

Top module: `secded_ram`

## Requirements
- R1: Check-code layout. Number the stored word's code positions 1..38. Data bit i sits at the i-th position, counting upward from 3, that is not a power of two. Check bit j (j = 0..5) is the XOR of the data bits whose position has bit j set. Check bit 6 is the XOR of all 32 data bits and check bits 0..5. `inj_val` uses this same bit order.
- R2: When `inj_en` is low, a write stores the generated code and `inj_val` has no effect. Reading that address returns the written data with both error flags low.
- R3: If exactly one bit of the 39-bit stored word differs from a valid codeword, a read returns the originally encoded data, raises `single_err` and keeps `double_err` low.
- R4: If the single difference lies only in a check bit, `rdata` equals the stored data bits unmodified and `single_err` is raised.
- R5: If exactly two bits differ, a read raises `double_err`, keeps `single_err` low, and returns the stored data bits uncorrected. The outcome for three or more differing bits is unspecified.
- R6: With `INJ_MODE=0`, a write with `inj_en` high stores `inj_val` as the complete 7-bit check code.
- R7: With `INJ_MODE=1`, a write with `inj_en` high stores the generated code XOR `inj_val`.
- R8: `rvalid` is high exactly one cycle after a cycle with `re` high. `rdata`, `single_err` and `double_err` are valid in that cycle. The flags are never high without `rvalid`, and never both high at once.
- R9: A read does not write corrected data back. Repeated reads of a corrupted word keep reporting the same error.
- R10: If `re` and `we` are high in the same cycle for the same address, the read returns the contents from before that write.
- R11: While `rst_n` is low, and in the first cycle after it, `rvalid`, `single_err` and `double_err` are low.
- R12: An `INJ_MODE` other than 0 or 1, a `DATA_W` outside 4..256, or an `ADDR_W` outside 1..16 stops elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset of the read-valid pipeline |
| re | input | 1 | Read request |
| we | input | 1 | Write request |
| addr | input | ADDR_W | Word address shared by read and write |
| wdata | input | DATA_W | Write data |
| inj_en | input | 1 | Replace or mask the generated check code on this write |
| inj_val | input | PAR_W+1 | Full check code (direct style) or XOR mask (mask style) |
| rdata | output | DATA_W | Corrected read data |
| rvalid | output | 1 | Read result valid |
| single_err | output | 1 | Corrected single-bit error on this read |
| double_err | output | 1 | Uncorrectable double-bit error on this read |

## Verification
Errors in the data bits are the hardest case to reach. Injection only touches the check code, so there is no direct way to flip a stored data bit.

The bench gets there with a neighbouring codeword. It writes the intended data with selected bits flipped, together with the check code it computed for the intended data: as the full code in direct style, or as the difference of the two codes as a mask in mask style. The result is a stored word that is one or two bit flips away from the intended codeword, with the flips at any of the 39 positions.

The bench sweeps every single flip position and every pair of positions. Both build styles are instantiated side by side and must agree on every read.

// File: rtl/secded_pkg.sv
package secded_pkg;

   localparam int MAX_DW     = 256;
   localparam int INJ_DIRECT = 0;
   localparam int INJ_XOR    = 1;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

   // number of position parity bits needed for dw data bits
   function automatic int par_bits(input int dw);
      int p;
      p = 0;
      while ((1 << p) < dw + p + 1) p++;
      return p;
   endfunction

   // codeword position of data bit idx (positions start at 1)
   function automatic int data_pos(input int idx);
      int pos;
      pos = 2;
      for (int i = 0; i <= idx; i++) begin
         pos++;
         while (is_pow2(pos)) pos++;
      end
      return pos;
   endfunction

   // data bits covered by position parity bit j
   function automatic logic [MAX_DW-1:0] cover_mask(input int j, input int dw);
      logic [MAX_DW-1:0] m;
      m = '0;
      for (int i = 0; i < dw; i++) begin
         if (((data_pos(i) >> j) & 1) == 1) m[i] = 1'b1;
      end
      return m;
   endfunction

endpackage

// File: rtl/secded_posgen.sv
module secded_posgen
   import secded_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int PAR_W  = par_bits(DATA_W)
) (
   input  logic [DATA_W-1:0] data,
   output logic [PAR_W-1:0]  pos_par
);

   for (genvar j = 0; j < PAR_W; j++) begin : g_par
      localparam logic [MAX_DW-1:0] COVER = cover_mask(j, DATA_W);
      assign pos_par[j] = ^(data & COVER[DATA_W-1:0]);
   end

endmodule

// File: rtl/secded_enc.sv
module secded_enc
   import secded_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int PAR_W  = par_bits(DATA_W)
) (
   input  logic [DATA_W-1:0] data,
   output logic [PAR_W:0]    code
);

   logic [PAR_W-1:0] pos_par;

   secded_posgen #(.DATA_W(DATA_W), .PAR_W(PAR_W)) posgen_i (
      .data    (data),
      .pos_par (pos_par)
   );

   assign code = {(^data) ^ (^pos_par), pos_par};

endmodule

// File: rtl/secded_inject.sv
module secded_inject
   import secded_pkg::*;
#(
   parameter int CODE_W   = 7,
   parameter int INJ_MODE = INJ_DIRECT
) (
   input  logic [CODE_W-1:0] gen_code,
   input  logic              inj_en,
   input  logic [CODE_W-1:0] inj_val,
   output logic [CODE_W-1:0] store_code
);

   if (INJ_MODE == INJ_XOR) begin : g_xor
      assign store_code = gen_code ^ (inj_en ? inj_val : '0);
   end else begin : g_direct
      assign store_code = inj_en ? inj_val : gen_code;
   end

endmodule

// File: rtl/secded_store.sv
module secded_store #(
   parameter int WORD_W = 39,
   parameter int ADDR_W = 4,
   localparam int DEPTH = 1 << ADDR_W
) (
   input  logic              clk,
   input  logic              we,
   input  logic              re,
   input  logic [ADDR_W-1:0] addr,
   input  logic [WORD_W-1:0] wword,
   output logic [WORD_W-1:0] rword
);

   logic [WORD_W-1:0] mem [DEPTH];

   // read-first: a read in a write cycle sees the old word
   always_ff @(posedge clk) begin
      if (re) rword <= mem[addr];
      if (we) mem[addr] <= wword;
   end

endmodule

// File: rtl/secded_dec.sv
module secded_dec
   import secded_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int PAR_W  = par_bits(DATA_W)
) (
   input  logic [DATA_W-1:0] data_q,
   input  logic [PAR_W:0]    code_q,
   output logic [DATA_W-1:0] data_fix,
   output logic              err_single,
   output logic              err_double
);

   logic [PAR_W-1:0]  pos_par;
   logic [PAR_W-1:0]  syndrome;
   logic              odd;
   logic [DATA_W-1:0] flip;

   secded_posgen #(.DATA_W(DATA_W), .PAR_W(PAR_W)) posgen_i (
      .data    (data_q),
      .pos_par (pos_par)
   );

   assign syndrome = pos_par ^ code_q[PAR_W-1:0];
   assign odd      = (^data_q) ^ (^code_q);

   for (genvar i = 0; i < DATA_W; i++) begin : g_fix
      localparam int POS = data_pos(i);
      assign flip[i] = odd && (syndrome == PAR_W'(POS));
   end

   assign data_fix   = data_q ^ flip;
   assign err_single = odd;
   assign err_double = !odd && (syndrome != '0);

endmodule

// File: rtl/secded_ram.sv
module secded_ram
   import secded_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 4,
   parameter int INJ_MODE = INJ_DIRECT,
   localparam int PAR_W   = par_bits(DATA_W),
   localparam int CODE_W  = PAR_W + 1,
   localparam int WORD_W  = DATA_W + CODE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              re,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              inj_en,
   input  logic [CODE_W-1:0] inj_val,
   output logic [DATA_W-1:0] rdata,
   output logic              rvalid,
   output logic              single_err,
   output logic              double_err
);

   // R12 elaboration-time parameter checks
   if (INJ_MODE != INJ_DIRECT && INJ_MODE != INJ_XOR) begin : g_bad_mode
      $error("secded_ram: INJ_MODE must be 0 or 1");
   end
   if (DATA_W < 4 || DATA_W > MAX_DW) begin : g_bad_dw
      $error("secded_ram: DATA_W out of range");
   end
   if (ADDR_W < 1 || ADDR_W > 16) begin : g_bad_aw
      $error("secded_ram: ADDR_W out of range");
   end

   logic [CODE_W-1:0] gen_code;
   logic [CODE_W-1:0] store_code;
   logic [WORD_W-1:0] rword;
   logic [DATA_W-1:0] data_fix;
   logic              err_single;
   logic              err_double;

   secded_enc #(.DATA_W(DATA_W), .PAR_W(PAR_W)) enc_i (
      .data (wdata),
      .code (gen_code)
   );

   secded_inject #(.CODE_W(CODE_W), .INJ_MODE(INJ_MODE)) inj_i (
      .gen_code   (gen_code),
      .inj_en     (inj_en),
      .inj_val    (inj_val),
      .store_code (store_code)
   );

   secded_store #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) store_i (
      .clk   (clk),
      .we    (we),
      .re    (re),
      .addr  (addr),
      .wword ({store_code, wdata}),
      .rword (rword)
   );

   secded_dec #(.DATA_W(DATA_W), .PAR_W(PAR_W)) dec_i (
      .data_q     (rword[DATA_W-1:0]),
      .code_q     (rword[WORD_W-1:DATA_W]),
      .data_fix   (data_fix),
      .err_single (err_single),
      .err_double (err_double)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rvalid <= 1'b0;
      else        rvalid <= re;
   end

   assign rdata      = data_fix;
   assign single_err = rvalid && err_single;
   assign double_err = rvalid && err_double;

endmodule

// File: rtl/secded_ram_chk.sv
module secded_ram_chk #(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 4,
   parameter int CODE_W = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              re,
   input logic              we,
   input logic [ADDR_W-1:0] addr,
   input logic [DATA_W-1:0] wdata,
   input logic              inj_en,
   input logic [CODE_W-1:0] inj_val,
   input logic [DATA_W-1:0] rdata,
   input logic              rvalid,
   input logic              single_err,
   input logic              double_err
);

   // R8
   read_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      re |=> rvalid);

   // R8
   no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !re |=> !rvalid);

   // R8
   flags_need_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (single_err || double_err) |-> rvalid);

   // R8
   flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(single_err && double_err));

   // R2
   clean_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(we) && !$past(inj_en) && re && !we && addr == $past(addr))
      |=> (rvalid && !single_err && !double_err && rdata == $past(wdata, 2)));

endmodule

bind secded_ram secded_ram_chk #(
   .DATA_W (DATA_W),
   .ADDR_W (ADDR_W),
   .CODE_W (CODE_W)
) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .re         (re),
   .we         (we),
   .addr       (addr),
   .wdata      (wdata),
   .inj_en     (inj_en),
   .inj_val    (inj_val),
   .rdata      (rdata),
   .rvalid     (rvalid),
   .single_err (single_err),
   .double_err (double_err)
);

// File: tb/secded_ram_tb.sv
`timescale 1ns/1ps
module secded_ram_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        re = 1'b0;
   logic        we = 1'b0;
   logic [3:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic        inj_en = 1'b0;
   logic [6:0]  val_d = '0;
   logic [6:0]  val_x = '0;
   logic [31:0] rdata_d, rdata_x;
   logic        rvalid_d, rvalid_x, se_d, se_x, de_d, de_x;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #2 clk = ~clk;

   secded_ram #(.DATA_W(32), .ADDR_W(4), .INJ_MODE(0)) dut_i (
      .clk(clk), .rst_n(rst_n), .re(re), .we(we), .addr(addr), .wdata(wdata),
      .inj_en(inj_en), .inj_val(val_d), .rdata(rdata_d), .rvalid(rvalid_d),
      .single_err(se_d), .double_err(de_d));

   secded_ram #(.DATA_W(32), .ADDR_W(4), .INJ_MODE(1)) dut_x (
      .clk(clk), .rst_n(rst_n), .re(re), .we(we), .addr(addr), .wdata(wdata),
      .inj_en(inj_en), .inj_val(val_x), .rdata(rdata_x), .rvalid(rvalid_x),
      .single_err(se_x), .double_err(de_x));

   // R1 code model, computed from the position rule
   function automatic logic [6:0] enc(input logic [31:0] d);
      logic [6:0] c = '0;
      int pos = 2;
      for (int i = 0; i < 32; i++) begin
         pos++;
         while ((pos & (pos - 1)) == 0) pos++;
         for (int j = 0; j < 6; j++) if (((pos >> j) & 1) == 1) c[j] ^= d[i];
      end
      c[6] = (^d) ^ (^c[5:0]);
      return c;
   endfunction

   task automatic check(input bit ok, input string req, input logic [63:0] act,
                        input logic [63:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d, input bit inj,
                     input logic [6:0] vd, input logic [6:0] vx);
      @(negedge clk);
      we = 1'b1; re = 1'b0; addr = a; wdata = d; inj_en = inj; val_d = vd; val_x = vx;
      @(negedge clk);
      we = 1'b0; inj_en = 1'b0;
   endtask

   // read and return {single,double} of both builds after checking they agree
   task automatic rd(input logic [3:0] a, output logic [31:0] d, output logic s,
                     output logic dbl);
      @(negedge clk);
      re = 1'b1; we = 1'b0; addr = a;
      @(negedge clk);
      re = 1'b0;
      check(rvalid_d && rvalid_x, "R8 rvalid after read", {rvalid_d, rvalid_x}, 2'b11);
      check({rdata_d, se_d, de_d} == {rdata_x, se_x, de_x}, "R6/R7 builds agree",
            {rdata_d, se_d, de_d}, {rdata_x, se_x, de_x});
      d = rdata_d; s = se_d; dbl = de_d;
   endtask

   // store d with the 39-bit flip pattern f applied, in both builds
   task automatic wr_flip(input logic [3:0] a, input logic [31:0] d, input logic [38:0] f);
      logic [31:0] wd;
      logic [6:0]  code;
      wd   = d ^ f[31:0];
      code = enc(d) ^ f[38:32];
      wr(a, wd, 1'b1, code, code ^ enc(wd));
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin : main
      logic [31:0] d, exp;
      logic        s, dbl;
      int          k;

      repeat (3) @(negedge clk);
      // R11 reset state
      check(!rvalid_d && !se_d && !de_d && !rvalid_x && !se_x && !de_x, "R11 reset",
            {rvalid_d, se_d, de_d}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!rvalid_d && !se_d && !de_d, "R11 after reset", {rvalid_d, se_d, de_d}, 0);

      // R2 clean writes with garbage inj_val, all addresses
      for (int a = 0; a < 16; a++)
         wr(4'(a), 32'hA5A5_0000 ^ (32'(a) * 32'h0101_0101), 1'b0, 7'h5A, 7'h33);
      for (int a = 0; a < 16; a++) begin
         exp = 32'hA5A5_0000 ^ (32'(a) * 32'h0101_0101);
         rd(4'(a), d, s, dbl);
         check(d == exp && !s && !dbl, "R2 clean readback", {d, s, dbl}, {exp, 2'b00});
      end

      // R1 R6 R7 injecting the exact golden code yields no error
      d = 32'hDEAD_BEEF;
      wr(4'd3, d, 1'b1, enc(d), 7'h00);
      rd(4'd3, exp, s, dbl);
      check(exp == d && !s && !dbl, "R1 golden code accepted", {exp, s, dbl}, {d, 2'b00});

      // R8 rvalid drops after an idle cycle
      @(negedge clk);
      check(!rvalid_d && !se_d && !de_d, "R8 idle", {rvalid_d, se_d, de_d}, 0);

      // R3 R4 every single flip position
      k = 0;
      for (int b = 0; b < 39; b++) begin
         d = 32'h9E37_79B9 * 32'(b + 1);
         wr_flip(4'(k), d, 39'd1 << b);
         rd(4'(k), exp, s, dbl);
         if (b >= 32)
            check(exp == d && s && !dbl, "R4 check-bit flip", {exp, s, dbl}, {d, 2'b10});
         else
            check(exp == d && s && !dbl, "R3 data-bit flip", {exp, s, dbl}, {d, 2'b10});
         k = (k + 1) % 16;
      end

      // R5 every pair of flip positions
      for (int b1 = 0; b1 < 39; b1++) begin
         for (int b2 = b1 + 1; b2 < 39; b2++) begin
            logic [38:0] f;
            f = (39'd1 << b1) | (39'd1 << b2);
            d = 32'h7F4A_7C15 ^ (32'(b1) << 8) ^ 32'(b2);
            wr_flip(4'(k), d, f);
            rd(4'(k), exp, s, dbl);
            check(exp == (d ^ f[31:0]) && !s && dbl, "R5 double flip",
                  {exp, s, dbl}, {d ^ f[31:0], 2'b01});
            k = (k + 1) % 16;
         end
      end

      // R9 no write-back: second read still reports
      d = 32'h1234_5678;
      wr_flip(4'd5, d, 39'd1 << 7);
      rd(4'd5, exp, s, dbl);
      rd(4'd5, exp, s, dbl);
      check(exp == d && s && !dbl, "R9 single persists", {exp, s, dbl}, {d, 2'b10});
      wr_flip(4'd6, d, (39'd1 << 2) | (39'd1 << 35));
      rd(4'd6, exp, s, dbl);
      rd(4'd6, exp, s, dbl);
      check(!s && dbl, "R9 double persists", {s, dbl}, 2'b01);

      // R10 read-first on simultaneous read and write
      wr(4'd9, 32'hCAFE_0001, 1'b0, 7'h0, 7'h0);
      @(negedge clk);
      re = 1'b1; we = 1'b1; addr = 4'd9; wdata = 32'hCAFE_0002;
      @(negedge clk);
      re = 1'b0; we = 1'b0;
      check(rdata_d == 32'hCAFE_0001 && rdata_x == 32'hCAFE_0001, "R10 old data",
            rdata_d, 32'hCAFE_0001);
      rd(4'd9, exp, s, dbl);
      check(exp == 32'hCAFE_0002 && !s && !dbl, "R10 new data", exp, 32'hCAFE_0002);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule